// File: doc/BRIEF.md
# Clock-Configuration Register Slave on a Two-Wire Bus

This block is a slave on a two-wire management bus. It holds a small bank of byte-wide configuration registers for a clock fan-out device. Register 0 drives the enable bits of the eight differential clock outputs, and the full bank is also brought out as a parallel image. Every register loads a fixed default at reset, so the clock device works without any bus traffic. A host can use the bus at system start to change individual settings.

The master first sends the slave address, then a command byte. If the top bit of the command is 1, the access is an indexed single-register access, and the low seven bits name the register. If the top bit is 0, the access is a block access, which always begins at register 0 and walks upward. A block write carries a byte count after the command. A block read returns a byte count first, then the registers in ascending order. A read is done as a command write, then a repeated START, then the address with the read bit set. The bus lines are sampled with the system clock, and the slave pulls the data line low for acknowledges and for zero bits of read data.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 1101110, sent as the byte DCh for a write and DDh for a read. For any other address it drives nothing and ignores all bytes until the next START.
- R2: The slave acknowledges every byte it receives once it is addressed by pulling the data line low during the ninth clock.
- R3: A command byte with bit 7 = 1 selects byte mode, and bits 6:0 give the register index. In byte mode the index does not advance: repeated data bytes go to the same register, and repeated reads return the same register.
- R4: A command byte with bit 7 = 0 selects block mode. The byte after the command is a count, which is acknowledged and not stored. The data bytes that follow are written to registers 0, 1, 2 and so on in ascending order.
- R5: A block read returns first the count of implemented registers (4 with the defaults), then the registers from index 0 upward. Indices past the last register read as 00h.
- R6: A write to an index past the last register is acknowledged and changes no register.
- R7: A STOP returns the slave to idle at any point. Every register written before the STOP keeps its new value, and a partly sent byte writes nothing.
- R8: At reset the registers take REG_DEFAULTS (register 3..0 = 5Ah, 00h, 00h, FFh). Bit i of register 0 is the enable for clock output i, and registers change only through bus writes.
- R9: Data is shifted most significant bit first. The slave changes its line drive only after a falling edge of SCL, or on START or STOP. It releases the line when the master does not acknowledge a read byte.
- R10: A byte-mode read of an index past the last register returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull_low | output | 1 | 1 = pull the data line low (open-drain drive) |
| dif_enable | output | 8 | Per-output enables for the eight differential clocks (register 0) |
| cfg_image | output | NUM_REGS*8 | All registers, register k in bits 8k+7:8k |

## Verification
The bench drives the bus in several patterns:
- indexed writes and reads;
- full-length, shortened and overlong block writes;
- a block read that runs past the last register;
- a foreign address;
- a STOP in the middle of a byte.

The shortened block write tells a design that commits bytes as they arrive apart from one that holds them until the count is reached. The overlong write and the read past the end show whether the index wraps or aliases. Repeating bytes in byte mode tells an advancing index apart from a fixed one. The foreign-address pattern shows whether the slave stays silent for the rest of that transfer.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_COUNT,
    ST_WDATA,
    ST_READ
  } smb_state_t;

  // Command bit 7 set means a single indexed register access.
  function automatic logic is_byte_cmd(input logic [7:0] cmd);
    return cmd[7];
  endfunction

  // Register index carried in the command's low seven bits.
  function automatic logic [7:0] cmd_index(input logic [7:0] cmd);
    return {1'b0, cmd[6:0]};
  endfunction

  // Block pointer step that stops at the top so it cannot alias to zero.
  function automatic logic [7:0] ptr_step(input logic [7:0] p);
    return (p == 8'hFF) ? p : p + 8'd1;
  endfunction

  // Transmit bit for a given bit slot, MSB first.
  function automatic logic tx_bit(input logic [7:0] b, input logic [2:0] slot);
    logic [2:0] sel;
    sel = 3'd7 - slot;
    return b[sel];
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_ff;
  logic [SYNC_STAGES-1:0] sda_ff;
  logic scl_d;
  logic sda_d;
  logic scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[SYNC_STAGES-1];
  assign sda_lvl   = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/smb_cfg_regfile.sv
module smb_cfg_regfile #(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 8,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] image
);

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= DEFAULTS[g*8 +: 8];
        end else if (wr_en && wr_idx == IDX_W'(g)) begin
          q <= wr_data;
        end
      end
      assign image[g*8 +: 8] = q;
    end
  endgenerate

  // Unimplemented indices read as zero.
  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = image[k*8 +: 8];
    end
  end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter logic [6:0] DEV_ADDR = 7'b1101110,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 32'h5A00_00FF,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull_low,
  output logic [7:0]            dif_enable,
  output logic [NUM_REGS*8-1:0] cfg_image
);

  localparam int IDX_W = 8;
  localparam logic [7:0] REG_COUNT = 8'(NUM_REGS);
  localparam logic [3:0] ACK_SLOT_CNT = 4'd8;

  // Bus events
  logic sda_lvl, scl_rise, scl_fall_evt, start_evt, stop_evt;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall_evt),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  // Protocol state
  smb_state_t state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] tx_byte;
  logic [7:0] ptr;
  logic       ack_slot;
  logic       blk_mode;
  logic       cnt_phase;
  logic       rd_first;
  logic       pull_q;

  // Named internal events
  logic       byte_done;
  logic       addr_hit;
  logic       addr_reject_evt;
  logic       wr_en;
  logic [7:0] rd_data;
  logic [7:0] rd_value;

  assign byte_done       = scl_fall_evt && (bit_cnt == ACK_SLOT_CNT) && !ack_slot;
  assign addr_hit        = (shreg[7:1] == DEV_ADDR);
  assign addr_reject_evt = byte_done && (state == ST_ADDR) && !addr_hit;
  assign wr_en           = byte_done && (state == ST_WDATA) && (ptr < REG_COUNT);
  assign rd_value        = (blk_mode && cnt_phase) ? REG_COUNT : rd_data;

  smb_cfg_regfile #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .DEFAULTS (REG_DEFAULTS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (ptr),
    .wr_data (shreg),
    .rd_idx  (ptr),
    .rd_data (rd_data),
    .image   (cfg_image)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx_byte   <= '0;
      ptr       <= '0;
      ack_slot  <= 1'b0;
      blk_mode  <= 1'b1;
      cnt_phase <= 1'b0;
      rd_first  <= 1'b0;
      pull_q    <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      ack_slot <= 1'b0;
      pull_q   <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      ack_slot <= 1'b0;
      pull_q   <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt == ACK_SLOT_CNT) begin
          bit_cnt <= '0;
          if (state == ST_READ) begin
            if (rd_first) begin
              rd_first <= 1'b0;
            end else if (sda_lvl) begin
              state <= ST_IDLE;           // master NACK ends the read
            end else if (cnt_phase) begin
              cnt_phase <= 1'b0;
            end else if (blk_mode) begin
              ptr <= ptr_step(ptr);
            end
          end
        end else begin
          bit_cnt <= bit_cnt + 4'd1;
          if (state != ST_READ) shreg <= {shreg[6:0], sda_lvl};
        end
      end else if (scl_fall_evt) begin
        if (ack_slot) begin
          ack_slot <= 1'b0;
          if (state == ST_READ) begin
            tx_byte <= rd_value;
            pull_q  <= ~rd_value[7];
          end else begin
            pull_q <= 1'b0;
          end
        end else if (bit_cnt == ACK_SLOT_CNT) begin
          ack_slot <= 1'b1;
          if (state == ST_READ) begin
            pull_q <= 1'b0;                // master owns the ack slot
          end else begin
            pull_q <= 1'b1;
            case (state)
              ST_ADDR: begin
                if (!addr_hit) begin
                  pull_q <= 1'b0;
                  state  <= ST_IDLE;
                end else if (shreg[0]) begin
                  state     <= ST_READ;
                  rd_first  <= 1'b1;
                  cnt_phase <= blk_mode;
                  if (blk_mode) ptr <= '0;
                end else begin
                  state <= ST_CMD;
                end
              end
              ST_CMD: begin
                blk_mode <= ~is_byte_cmd(shreg);
                ptr      <= is_byte_cmd(shreg) ? cmd_index(shreg) : 8'h00;
                state    <= is_byte_cmd(shreg) ? ST_WDATA : ST_COUNT;
              end
              ST_COUNT: state <= ST_WDATA;
              ST_WDATA: if (blk_mode) ptr <= ptr_step(ptr);
              default:  pull_q <= 1'b0;
            endcase
          end
        end else if (state == ST_READ) begin
          pull_q <= ~tx_bit(tx_byte, bit_cnt[2:0]);
        end
      end
    end
  end

  assign sda_pull_low = pull_q;
  assign dif_enable   = cfg_image[7:0];

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int IMG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_fall_evt,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sda_pull_low,
  input logic             wr_en,
  input logic             addr_reject_evt,
  input logic [IMG_W-1:0] cfg_image
);

  // R9
  drive_moves_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> $past(scl_fall_evt || start_evt || stop_evt));

  // R7
  stop_releases_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull_low);

  // R1
  foreign_addr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_reject_evt |=> !sda_pull_low);

  // R2
  written_byte_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_pull_low);

  // R8
  image_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_image) |-> $past(wr_en));

  // R1
  start_line_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull_low);

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.IMG_W(NUM_REGS*8)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .scl_fall_evt    (scl_fall_evt),
  .start_evt       (start_evt),
  .stop_evt        (stop_evt),
  .sda_pull_low    (sda_pull_low),
  .wr_en           (wr_en),
  .addr_reject_evt (addr_reject_evt),
  .cfg_image       (cfg_image)
);

// File: tb/smb_cfg_slave_test.sv
module smb_cfg_slave_test;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull_low;
  logic [7:0] dif_enable;
  logic [31:0] cfg_image;

  int checks = 0;
  int fails = 0;
  int img_mism = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;

  // Reference register bank: reg k in bits 8k+7:8k.
  logic [7:0] mdl [4];

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_low;

  smb_cfg_slave uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_m),
    .sda_in       (sda_line),
    .sda_pull_low (sda_pull_low),
    .dif_enable   (dif_enable),
    .cfg_image    (cfg_image)
  );

  function automatic logic [31:0] mdl_img();
    return {mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  // Every idle clock: the register image must match the reference bank.
  always @(negedge clk) begin
    if (quiet && rst_n && cfg_image !== mdl_img()) img_mism++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    quiet = 1'b0;
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half(); half();
    quiet = 1'b1;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; half();
    scl_m = 1'b1; half(); half();
    scl_m = 1'b0; half();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    b = sda_line; half();
    scl_m = 1'b0; half();
  endtask

  task automatic send(input logic [7:0] v, input logic exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    check(req, {31'd0, !a}, {31'd0, exp_ack});
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(!give_ack);
    sda_m = 1'b1;
  endtask

  logic [7:0] rb;

  initial begin
    for (int k = 0; k < 4; k++) mdl[k] = 8'h00;
    mdl[0] = 8'hFF; mdl[3] = 8'h5A;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset state
    check("R8 reset image", cfg_image, 32'h5A00_00FF);
    check("R8 reset enables", {24'd0, dif_enable}, 32'h0000_00FF);
    check("R9 idle line", {31'd0, sda_pull_low}, 32'd0);
    quiet = 1'b1;

    // R3 byte write to register 1
    bus_start();
    send(8'hDC, 1'b1, "R1 write address");
    send(8'h81, 1'b1, "R2 command ack");
    send(8'h3C, 1'b1, "R2 data ack");
    bus_stop();
    mdl[1] = 8'h3C;
    check("R3 byte write", cfg_image, mdl_img());

    // R9 byte read of register 1
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h81, 1'b1, "R3 command");
    bus_start();
    send(8'hDD, 1'b1, "R1 read address");
    recv(1'b0, rb);
    check("R9 byte read msb first", {24'd0, rb}, 32'h3C);
    check("R9 released after NACK", {31'd0, sda_pull_low}, 32'd0);
    bus_stop();

    // R4 full block write
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h00, 1'b1, "R4 block command");
    send(8'h04, 1'b1, "R4 count ack");
    send(8'hA1, 1'b1, "R4 data0");
    send(8'hB2, 1'b1, "R4 data1");
    send(8'hC3, 1'b1, "R4 data2");
    send(8'hD4, 1'b1, "R4 data3");
    bus_stop();
    mdl[0] = 8'hA1; mdl[1] = 8'hB2; mdl[2] = 8'hC3; mdl[3] = 8'hD4;
    check("R4 block write", cfg_image, mdl_img());
    check("R8 enables follow reg0", {24'd0, dif_enable}, 32'hA1);

    // R7 shortened block write
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h00, 1'b1, "R4 block command");
    send(8'h04, 1'b1, "R4 count");
    send(8'h11, 1'b1, "R7 data0");
    send(8'h22, 1'b1, "R7 data1");
    bus_stop();
    mdl[0] = 8'h11; mdl[1] = 8'h22;
    check("R7 early stop keeps bytes", cfg_image, mdl_img());

    // R6 overlong block write
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h00, 1'b1, "R4 block command");
    send(8'h06, 1'b1, "R4 count");
    for (int k = 1; k <= 6; k++) send(8'(k), 1'b1, "R6 every byte acked");
    bus_stop();
    mdl[0] = 8'h01; mdl[1] = 8'h02; mdl[2] = 8'h03; mdl[3] = 8'h04;
    check("R6 extra bytes ignored", cfg_image, mdl_img());

    // R5 block read running past the end
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h00, 1'b1, "R4 block command");
    bus_start();
    send(8'hDD, 1'b1, "R1 read address");
    recv(1'b1, rb);
    check("R5 count byte", {24'd0, rb}, 32'd4);
    for (int k = 0; k < 6; k++) begin
      recv(k != 5, rb);
      check("R5 block read data", {24'd0, rb}, (k < 4) ? {24'd0, mdl[k]} : 32'd0);
    end
    bus_stop();

    // R1 foreign address: no ack, rest of transfer ignored
    bus_start();
    send(8'hDE, 1'b0, "R1 foreign address NACK");
    send(8'h80, 1'b0, "R1 command ignored");
    send(8'h55, 1'b0, "R1 data ignored");
    bus_stop();
    check("R1 foreign write no effect", cfg_image, mdl_img());

    // R6 / R10 out-of-range index
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h85, 1'b1, "R3 command");
    send(8'h99, 1'b1, "R6 out-of-range acked");
    bus_stop();
    check("R6 out-of-range write ignored", cfg_image, mdl_img());
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h85, 1'b1, "R3 command");
    bus_start();
    send(8'hDD, 1'b1, "R1 read address");
    recv(1'b0, rb);
    check("R10 out-of-range reads zero", {24'd0, rb}, 32'd0);
    bus_stop();

    // R3 byte mode index does not advance
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h82, 1'b1, "R3 command");
    send(8'h77, 1'b1, "R3 data first");
    send(8'h66, 1'b1, "R3 data second");
    bus_stop();
    mdl[2] = 8'h66;
    check("R3 same register rewritten", cfg_image, mdl_img());
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h82, 1'b1, "R3 command");
    bus_start();
    send(8'hDD, 1'b1, "R1 read address");
    recv(1'b1, rb);
    check("R3 byte read first", {24'd0, rb}, 32'h66);
    recv(1'b0, rb);
    check("R3 byte read repeats", {24'd0, rb}, 32'h66);
    bus_stop();

    // R7 STOP inside a data byte
    bus_start();
    send(8'hDC, 1'b1, "R1 address");
    send(8'h80, 1'b1, "R3 command");
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check("R7 partial byte writes nothing", cfg_image, mdl_img());
    check("R7 line free after stop", {31'd0, sda_pull_low}, 32'd0);
    bus_start();
    send(8'hDC, 1'b1, "R7 address after abort");
    send(8'h80, 1'b1, "R3 command");
    bus_start();
    send(8'hDD, 1'b1, "R1 read address");
    recv(1'b0, rb);
    check("R7 slave usable after abort", {24'd0, rb}, {24'd0, mdl[0]});
    bus_stop();

    check("R8 image matched reference every idle clock", img_mism, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule